// File: doc/BRIEF.md
# Serial Port Interrupt Identification

This block sits beside the register bank of a PC-style serial controller and decides which interrupt, if any, the controller is raising. Four conditions feed it: a receive error event, receive data at or above the trigger level, the transmit holding register having become empty, and a change on the modem inputs. Each is masked by its bit of the interrupt-enable value. The highest-priority survivor is reported as a two-bit code on a read-only identity byte.

The identity byte uses an active-low "nothing pending" flag in bit 0 and two bits that mirror whether the FIFOs are on. A single interrupt line leaves the block, gated by a master-enable bit taken from the modem control register. The register bank supplies read and write strobes. These strobes clear the sticky conditions: a line-status read, a modem-status read, a holding-register write, or an identity read that returns the transmit code.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable bit 0 masks received data, bit 1 transmit empty, bit 2 line status and bit 3 modem status; a disabled source never appears in the identity byte or on the interrupt line.
- R2: Identity bit 0 is 0 while any enabled source is pending and 1 otherwise; it changes in the same cycle as the pending set changes.
- R3: Identity bits [2:1] give the winning source: 11 line status, 10 received data, 01 transmit empty, 00 modem status. Line status outranks received data, which outranks transmit empty, which outranks modem status. With nothing pending, bits [2:1] are 00.
- R4: The interrupt output is high exactly when the master-enable input is 1 and an enabled source is pending.
- R5: Identity bits [7:6] are 11 while the FIFO-enable input is 1 and 00 otherwise; bits [5:3] are always 0.
- R6: Received data is pending while the receive level is nonzero and not below the trigger level; it stops pending in the cycle the level falls below the trigger.
- R7: Transmit empty becomes pending on the clock edge after the empty input rises. It is cleared by a holding-register write, or by an identity read in a cycle where the byte reports code 01.
- R8: Transmit empty also becomes pending on the edge after its enable bit goes from 0 to 1 while the empty input is 1.
- R9: Line status becomes pending on the edge after an error event and clears on the edge after a line-status read; if both occur in the same cycle, it stays pending.
- R10: Modem status becomes pending on the edge after a modem change event and clears on the edge after a modem-status read; if both occur in the same cycle, it stays pending.
- R11: An identity read while the byte reports any code other than 01 leaves a pending transmit-empty condition in place.
- R12: After reset no source is pending, the identity byte reads 0x01 with FIFOs off, and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_i | input | 4 | Interrupt-enable register value |
| out2_i | input | 1 | Master interrupt enable from modem control |
| fifo_on_i | input | 1 | FIFOs enabled |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive trigger level |
| tx_empty_i | input | 1 | Transmit holding register empty |
| thr_wr_i | input | 1 | Holding-register write strobe |
| iid_rd_i | input | 1 | Identity register read strobe |
| line_evt_i | input | 1 | Receive error event pulse |
| line_rd_i | input | 1 | Line-status read strobe |
| modem_evt_i | input | 1 | Modem input change pulse |
| modem_rd_i | input | 1 | Modem-status read strobe |
| iid_o | output | 8 | Identity byte |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case is an identity read that must leave transmit-empty pending because a higher-priority source is being reported at that moment. The stimulus first re-arms transmit empty through an enable 0-to-1 toggle. It then raises a line error on top of it, reads the identity while line status wins, and clears line status to show that code 01 reappears. Simultaneous set and clear strobes, and a receive level falling just below its trigger, are driven directly. A long stretch of random strobes is then compared against a cycle model every clock.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

   localparam int unsigned NUM_SRC = 4;
   localparam int unsigned CODE_W  = $clog2(NUM_SRC);

   // Source codes double as priority rank: larger value wins.
   typedef enum logic [CODE_W-1:0] {
      SRC_MODEM  = 2'b00,
      SRC_THRE   = 2'b01,
      SRC_RXDATA = 2'b10,
      SRC_LINE   = 2'b11
   } iid_src_e;

   function automatic logic [7:0] pack_id(input logic fifo_on,
                                          input logic [CODE_W-1:0] code,
                                          input logic none);
      pack_id = {fifo_on, fifo_on, 3'b000, code, none};
   endfunction

endpackage

// File: rtl/uart_iid_sticky.sv
module uart_iid_sticky #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   generate
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (set_i) flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
         end
         // R9 / R10: a new event survives a coincident read
         p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> flag_o);
      end else begin : g_clr_wins
         always_ff @(posedge clk) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (clr_i) flag_q <= 1'b0;
            else if (set_i) flag_q <= 1'b1;
         end
      end
   endgenerate

   assign flag_o = flag_q;

   // R9 / R10: a read with no new event clears the flag
   p_sticky_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/uart_iid_thre.sv
module uart_iid_thre (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_empty_i,
   input  logic en_i,
   input  logic wr_i,
   input  logic id_rd_i,
   input  logic reporting_i,
   output logic pend_o
);

   logic tx_q, en_q, pend_q;
   logic arm, disarm;

   assign arm    = tx_empty_i & (~tx_q | (en_i & ~en_q));
   assign disarm = wr_i | (id_rd_i & reporting_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q   <= 1'b1;
         en_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         tx_q <= tx_empty_i;
         en_q <= en_i;
         if (arm)         pend_q <= 1'b1;
         else if (disarm) pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;

   p_thre_wr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !arm) |=> !pend_o);

   p_thre_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty_i && en_i && !en_q) |=> pend_o);

   p_thre_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && id_rd_i && !reporting_i && !wr_i) |=> pend_o);

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio #(
   parameter int unsigned N = 4,
   localparam int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [CW-1:0] code_o
);

   generate
      if (N < 2) begin : g_bad_n
         $error("uart_iid_prio needs at least two sources");
      end
   endgenerate

   logic [N:0]   above;
   logic [N-1:0] grant;

   assign above[N] = 1'b0;

   generate
      for (genvar g = 0; g < N; g++) begin : g_rank
         assign grant[g] = req_i[g] & ~above[g+1];
         assign above[g] = above[g+1] | req_i[g];
      end
   endgenerate

   always_comb begin
      code_o = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) code_o = code_o | CW'(i);
      end
   end

   assign any_o = above[0];

   always_comb begin
      p_single_grant_r3: assert ($onehot0(grant));
   end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_iid_pkg::*;
#(
   parameter int unsigned LVL_W    = 5,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       ier_i,
   input  logic             out2_i,
   input  logic             fifo_on_i,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic [LVL_W-1:0] rx_trig_i,
   input  logic             tx_empty_i,
   input  logic             thr_wr_i,
   input  logic             iid_rd_i,
   input  logic             line_evt_i,
   input  logic             line_rd_i,
   input  logic             modem_evt_i,
   input  logic             modem_rd_i,
   output logic [7:0]       iid_o,
   output logic             irq_o
);

   generate
      if (LVL_W < 1) begin : g_bad_lvl
         $error("LVL_W must be at least 1");
      end
   endgenerate

   logic              line_pend, modem_pend, thre_pend, rx_pend;
   logic [NUM_SRC-1:0] req;
   logic              any;
   logic [CODE_W-1:0] code;
   logic              thre_reported;

   uart_iid_sticky #(.SET_WINS(SET_WINS)) u_line (
      .clk(clk), .rst_n(rst_n),
      .set_i(line_evt_i), .clr_i(line_rd_i), .flag_o(line_pend)
   );

   uart_iid_sticky #(.SET_WINS(SET_WINS)) u_modem (
      .clk(clk), .rst_n(rst_n),
      .set_i(modem_evt_i), .clr_i(modem_rd_i), .flag_o(modem_pend)
   );

   uart_iid_thre u_thre (
      .clk(clk), .rst_n(rst_n),
      .tx_empty_i(tx_empty_i), .en_i(ier_i[1]),
      .wr_i(thr_wr_i), .id_rd_i(iid_rd_i),
      .reporting_i(thre_reported), .pend_o(thre_pend)
   );

   assign rx_pend = (rx_level_i != '0) && (rx_level_i >= rx_trig_i);

   // Index of each request equals its identity code.
   assign req[SRC_LINE]   = line_pend  & ier_i[2];
   assign req[SRC_RXDATA] = rx_pend    & ier_i[0];
   assign req[SRC_THRE]   = thre_pend  & ier_i[1];
   assign req[SRC_MODEM]  = modem_pend & ier_i[3];

   uart_iid_prio #(.N(NUM_SRC)) u_prio (
      .req_i(req), .any_o(any), .code_o(code)
   );

   assign thre_reported = any && (code == SRC_THRE);
   assign iid_o         = pack_id(fifo_on_i, code, ~any);
   assign irq_o         = any & out2_i;

   p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (out2_i && !iid_o[0]));

   p_fifo_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (iid_o[7:6] == {2{fifo_on_i}}) && (iid_o[5:3] == 3'b000));

   p_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !iid_o[0] |-> (ier_i != 4'b0000));

   p_line_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_i[2] && line_pend) |-> (iid_o[2:0] == 3'b110));

   p_rx_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level_i < rx_trig_i) |-> (iid_o[2:0] != 3'b100));

   p_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iid_o[0] |-> (iid_o[2:1] == 2'b00));

endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

   localparam int LW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    ier_i = '0;
   logic          out2_i = 1'b0, fifo_on_i = 1'b0;
   logic [LW-1:0] rx_level_i = '0, rx_trig_i = 5'd1;
   logic          tx_empty_i = 1'b0, thr_wr_i = 1'b0, iid_rd_i = 1'b0;
   logic          line_evt_i = 1'b0, line_rd_i = 1'b0;
   logic          modem_evt_i = 1'b0, modem_rd_i = 1'b0;
   logic [7:0]    iid_o;
   logic          irq_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   uart_irq_ident #(.LVL_W(LW)) u_uart_irq_ident (
      .clk(clk), .rst_n(rst_n), .ier_i(ier_i), .out2_i(out2_i),
      .fifo_on_i(fifo_on_i), .rx_level_i(rx_level_i), .rx_trig_i(rx_trig_i),
      .tx_empty_i(tx_empty_i), .thr_wr_i(thr_wr_i), .iid_rd_i(iid_rd_i),
      .line_evt_i(line_evt_i), .line_rd_i(line_rd_i),
      .modem_evt_i(modem_evt_i), .modem_rd_i(modem_rd_i),
      .iid_o(iid_o), .irq_o(irq_o)
   );

   // Behavioural reference state
   bit m_line, m_modem, m_te, m_txprev, m_enprev;

   function automatic int winner();
      if (ier_i[2] && m_line) return 3;
      if (ier_i[0] && rx_level_i != 0 && rx_level_i >= rx_trig_i) return 2;
      if (ier_i[1] && m_te) return 1;
      if (ier_i[3] && m_modem) return 0;
      return -1;
   endfunction

   function automatic logic [8:0] expect_now();
      int w;
      logic [7:0] b;
      w = winner();
      b = {fifo_on_i, fifo_on_i, 6'b0};
      if (w < 0) b[0] = 1'b1;
      else       b[2:1] = w[1:0];
      return {out2_i && (w >= 0), b};
   endfunction

   always @(posedge clk) begin
      int w;
      bit te_up;
      if (!rst_n) begin
         m_line <= 0; m_modem <= 0; m_te <= 0; m_txprev <= 1; m_enprev <= 0;
      end else begin
         w = winner();
         te_up = tx_empty_i && (!m_txprev || (ier_i[1] && !m_enprev));
         if (te_up) m_te <= 1;
         else if (thr_wr_i || (iid_rd_i && w == 1)) m_te <= 0;
         if (line_evt_i) m_line <= 1; else if (line_rd_i) m_line <= 0;
         if (modem_evt_i) m_modem <= 1; else if (modem_rd_i) m_modem <= 0;
         m_txprev <= tx_empty_i;
         m_enprev <= ier_i[1];
      end
   end

   task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: {irq,iid} actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) chk("R2 R3 cycle model", {irq_o, iid_o}, expect_now());
   end

   task automatic cyc();
      @(posedge clk);
      #5;
   endtask

   task automatic look(input string tag, input logic [8:0] exp);
      #1;
      chk(tag, {irq_o, iid_o}, exp);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      look("R12 reset idle", 9'h001);

      // R1: everything pending but masked
      tx_empty_i = 1; line_evt_i = 1; modem_evt_i = 1;
      rx_level_i = 5'd4; rx_trig_i = 5'd4;
      cyc();
      line_evt_i = 0; modem_evt_i = 0;
      look("R1 all masked", 9'h001);
      ier_i = 4'b0001;
      look("R1 R6 rx at trigger", 9'h004);
      ier_i = 4'b1111;
      look("R4 out2 low blocks pin", 9'h006);
      out2_i = 1;
      look("R3 line outranks all", 9'h106);

      line_rd_i = 1; cyc(); line_rd_i = 0;
      look("R9 line read clears", 9'h104);
      rx_level_i = 5'd3;
      look("R6 below trigger", 9'h102);
      iid_rd_i = 1; cyc(); iid_rd_i = 0;
      look("R7 identity read clears thre", 9'h100);
      modem_rd_i = 1; cyc(); modem_rd_i = 0;
      look("R10 modem read clears", 9'h001);
      fifo_on_i = 1;
      look("R5 fifo bits", 9'h0C1);
      fifo_on_i = 0;

      // R8: enable toggle re-arms while empty
      ier_i = 4'b1101; cyc();
      ier_i = 4'b1111; cyc();
      look("R8 enable rising re-arms", 9'h102);
      line_evt_i = 1; cyc(); line_evt_i = 0;
      iid_rd_i = 1; cyc(); iid_rd_i = 0;
      look("R11 read while line shown", 9'h106);
      line_rd_i = 1; cyc(); line_rd_i = 0;
      look("R11 thre survived", 9'h102);

      thr_wr_i = 1; tx_empty_i = 0; cyc(); thr_wr_i = 0;
      look("R7 write clears", 9'h001);
      tx_empty_i = 1; cyc();
      look("R7 empty rising sets", 9'h102);

      line_evt_i = 1; line_rd_i = 1; cyc();
      line_evt_i = 0; line_rd_i = 0;
      look("R9 event beats read", 9'h106);
      modem_evt_i = 1; modem_rd_i = 1; line_rd_i = 1; cyc();
      modem_evt_i = 0; modem_rd_i = 0; line_rd_i = 0;
      thr_wr_i = 1; cyc(); thr_wr_i = 0;
      look("R10 event beats read", 9'h100);

      // random stretch checked by the cycle model
      for (int k = 0; k < 600; k++) begin
         ier_i       = 4'($urandom);
         out2_i      = 1'($urandom);
         fifo_on_i   = ($urandom % 8) == 0;
         rx_level_i  = LW'($urandom % 10);
         rx_trig_i   = LW'($urandom % 8);
         tx_empty_i  = ($urandom % 3) != 0;
         thr_wr_i    = ($urandom % 6) == 0;
         iid_rd_i    = ($urandom % 3) == 0;
         line_evt_i  = ($urandom % 7) == 0;
         line_rd_i   = ($urandom % 5) == 0;
         modem_evt_i = ($urandom % 7) == 0;
         modem_rd_i  = ($urandom % 5) == 0;
         cyc();
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule